// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block turns a single page-read request into the ordered set of register writes that an indexed-access NAND flash controller needs, then watches the controller's interrupt status until the page has been loaded. A request names a page, a bank and the area to read. The main area is read with error correction on. The spare area is read with error correction off. The block drives a one-cycle register write bus and a register read bus. The write bus reaches two spaces: the controller's register file, and a two-word indexed window that holds an address word and a data word.

After the command is issued, the block reads the bank's interrupt status once per poll interval. It stops with an error when the uncorrectable-ECC bit is seen. It stops cleanly when the load-complete bit is seen. It stops with a timeout when a fixed number of polls have found neither bit. In every case the result is reported with a one-cycle `done` pulse. Moving the page data out of the controller is left to other logic.

Top module: `nand_page_read_seq`

## Requirements
- R1: While and after reset, with no request, `req_ready` is 1 and `wr_en`, `rd_en`, `done`, `err_uncor` and `err_timeout` are all 0.
- R2: The first write of an accepted request goes to the register space (`wr_space`=0) at `ECC_OFS`. Its data is 1 for a main-area read (`req_main`=1) and 0 for a spare-area read.
- R3: The second write goes to the register space at `INT_BASE + bank*INT_STRIDE` with data 0x0000FFFF. This clears that bank's interrupt status.
- R4: Five window writes follow (`wr_space`=1). Offset 0x0 holds the address word and offset 0x10 holds the data word. With A = (bank<<24)|page, the writes in order are:
  - (0x0, (2<<26)|A)
  - (0x10, 0x42 for main or 0x41 for spare)
  - (0x0, (2<<26)|A)
  - (0x10, 0x2000|1)
  - (0x0, (1<<26)|A)
  All seven writes of a request fall in seven consecutive cycles, and the first comes two cycles after the accepting edge.
- R5: Each poll waits `POLL_IVL` idle cycles and then raises `rd_en` for one cycle at the bank's interrupt status address. The status word is expected on `rd_data` in the cycle after `rd_en`. The first wait begins right after the last command write, and each later wait begins in the cycle after a poll that found neither bit.
- R6: When the status word has bit `UNCOR_BIT` set, the block finishes with `done`=1 and `err_uncor`=1. This holds even if bit `LOAD_BIT` is set in the same word.
- R7: When bit `LOAD_BIT` is set and bit `UNCOR_BIT` is clear, the block finishes with `done`=1 and both error flags at 0.
- R8: When `MAX_POLLS` polls in a row have found neither bit, the block finishes with `done`=1 and `err_timeout`=1. Completion seen on the last allowed poll counts as success. The poll count restarts with every request.
- R9: A request is taken only while `req_ready` is 1. `req_valid` raised during a busy sequence is ignored and does not change any written word or the number of writes.
- R10: `done` is high for exactly one cycle per request. The error flags are 0 whenever `done` is 0. `req_ready` returns to 1 in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and takes a request |
| req_main | input | 1 | 1 = main-area read, 0 = spare-area read |
| req_bank | input | BANK_W | Bank number |
| req_page | input | PAGE_W | Page address |
| wr_en | output | 1 | Register write strobe |
| wr_space | output | 1 | 0 = register file, 1 = indexed window |
| wr_addr | output | ADDR_W | Write offset |
| wr_data | output | 32 | Write data |
| rd_en | output | 1 | Status read strobe |
| rd_addr | output | ADDR_W | Status read offset |
| rd_data | input | 32 | Status word, valid the cycle after rd_en |
| done | output | 1 | One-cycle completion pulse |
| err_uncor | output | 1 | Uncorrectable ECC seen, valid with done |
| err_timeout | output | 1 | Poll budget used up, valid with done |

## Verification
Two outcomes can be decided on the same status word. The first case is a word with both the uncorrectable-ECC bit and the load-complete bit set; the bench scripts such a word for the first poll and also for the last allowed poll, and expects the error outcome. The second case is load-complete arriving on exactly the final permitted poll, where success and timeout compete; the bench scripts this and expects a clean finish with no timeout flag. The bench's controller model answers each read from a scripted queue, and its reference timeline predicts every cycle of bus activity and the exact `done` cycle, so a wrong priority or an off-by-one poll budget shows up as a mismatch.

// File: rtl/nprs_pkg.sv
package nprs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ECC, ST_CLR, ST_C1A, ST_C1D, ST_C2A, ST_C2D, ST_C3A,
    ST_WAIT, ST_RD, ST_GAP, ST_CHK
  } step_t;

  localparam logic [31:0] KIND_SPARE = 32'h0000_0041;
  localparam logic [31:0] KIND_MAIN  = 32'h0000_0042;
  localparam logic [31:0] PIPE_FLAG  = 32'h0000_2000;
  localparam logic [31:0] CLEAR_ALL  = 32'h0000_FFFF;
  localparam logic [1:0]  MODE_CTRL  = 2'd2;
  localparam logic [1:0]  MODE_DATA  = 2'd1;
  localparam int          WIN_ADDR_OFS = 'h0;
  localparam int          WIN_DATA_OFS = 'h10;

endpackage

// File: rtl/nprs_word_gen.sv
module nprs_word_gen import nprs_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_W     = 24,
  parameter int BANK_W     = 2,
  parameter int ECC_OFS    = 'h0E0,
  parameter int INT_BASE   = 'h410,
  parameter int INT_STRIDE = 'h050,
  parameter int PAGE_COUNT = 1
) (
  input  step_t              step,
  input  logic [PAGE_W-1:0]  page,
  input  logic [BANK_W-1:0]  bank,
  input  logic               main_area,
  output logic               wr,
  output logic               space,
  output logic [ADDR_W-1:0]  addr,
  output logic [31:0]        data,
  output logic               rd,
  output logic [ADDR_W-1:0]  stat_addr
);

  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_ADDR_OFS);
  localparam logic [ADDR_W-1:0] WIN_D = ADDR_W'(WIN_DATA_OFS);

  logic [31:0] target;
  logic [31:0] ctrl_word;
  logic [31:0] data_word;

  assign target    = {{(32-PAGE_W){1'b0}}, page} | (32'(bank) << 24);
  assign ctrl_word = target | (32'(MODE_CTRL) << 26);
  assign data_word = target | (32'(MODE_DATA) << 26);
  assign stat_addr = ADDR_W'(INT_BASE + int'(bank) * INT_STRIDE);

  always_comb begin
    wr    = 1'b0;
    space = 1'b0;
    addr  = '0;
    data  = '0;
    rd    = 1'b0;
    case (step)
      ST_ECC: begin
        wr = 1'b1; addr = ADDR_W'(ECC_OFS); data = {31'd0, main_area};
      end
      ST_CLR: begin
        wr = 1'b1; addr = stat_addr; data = CLEAR_ALL;
      end
      ST_C1A, ST_C2A: begin
        wr = 1'b1; space = 1'b1; addr = WIN_A; data = ctrl_word;
      end
      ST_C1D: begin
        wr = 1'b1; space = 1'b1; addr = WIN_D;
        data = main_area ? KIND_MAIN : KIND_SPARE;
      end
      ST_C2D: begin
        wr = 1'b1; space = 1'b1; addr = WIN_D;
        data = PIPE_FLAG | 32'(PAGE_COUNT);
      end
      ST_C3A: begin
        wr = 1'b1; space = 1'b1; addr = WIN_A; data = data_word;
      end
      ST_RD:   rd = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/nprs_poll_timer.sv
module nprs_poll_timer #(
  parameter int POLL_IVL  = 100,
  parameter int MAX_POLLS = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic arm,
  input  logic miss,
  output logic tick,
  output logic last_poll
);

  localparam int IVL_W = (POLL_IVL > 1) ? $clog2(POLL_IVL) : 1;
  localparam int PC_W  = $clog2(MAX_POLLS + 1);
  localparam logic [IVL_W-1:0] IVL_LAST = IVL_W'(POLL_IVL - 1);
  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(MAX_POLLS - 1);

  logic [IVL_W-1:0] ivl_cnt;
  logic [PC_W-1:0]  poll_cnt;

  assign tick      = arm && (ivl_cnt == IVL_LAST);
  assign last_poll = (poll_cnt == PC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || tick) ivl_cnt <= '0;
    else                     ivl_cnt <= ivl_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || start) poll_cnt <= '0;
    else if (miss)    poll_cnt <= poll_cnt + 1'b1;
  end

endmodule

// File: rtl/nand_page_read_seq.sv
module nand_page_read_seq import nprs_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_W     = 24,
  parameter int BANK_W     = 2,
  parameter int ECC_OFS    = 'h0E0,
  parameter int INT_BASE   = 'h410,
  parameter int INT_STRIDE = 'h050,
  parameter int LOAD_BIT   = 12,
  parameter int UNCOR_BIT  = 0,
  parameter int POLL_IVL   = 100,
  parameter int MAX_POLLS  = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_main,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PAGE_W-1:0] req_page,
  output logic              wr_en,
  output logic              wr_space,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              done,
  output logic              err_uncor,
  output logic              err_timeout
);

  step_t             step, step_nx;
  logic [PAGE_W-1:0] page_q;
  logic [BANK_W-1:0] bank_q;
  logic              main_q;

  logic              accept, tick, last_poll;
  logic              st_uncor, st_load, in_chk, miss, finish;
  logic              g_wr, g_space, g_rd;
  logic [ADDR_W-1:0] g_addr, g_stat;
  logic [31:0]       g_data;
  logic              unused_status;

  assign req_ready     = (step == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign st_uncor      = rd_data[UNCOR_BIT];
  assign st_load       = rd_data[LOAD_BIT];
  assign unused_status = ^rd_data;
  assign in_chk        = (step == ST_CHK);
  assign miss          = in_chk && !st_uncor && !st_load;
  assign finish        = in_chk && (st_uncor || st_load || last_poll);

  always_comb begin
    step_nx = step;
    case (step)
      ST_IDLE: if (req_valid) step_nx = ST_ECC;
      ST_ECC:  step_nx = ST_CLR;
      ST_CLR:  step_nx = ST_C1A;
      ST_C1A:  step_nx = ST_C1D;
      ST_C1D:  step_nx = ST_C2A;
      ST_C2A:  step_nx = ST_C2D;
      ST_C2D:  step_nx = ST_C3A;
      ST_C3A:  step_nx = ST_WAIT;
      ST_WAIT: if (tick) step_nx = ST_RD;
      ST_RD:   step_nx = ST_GAP;
      ST_GAP:  step_nx = ST_CHK;
      ST_CHK:  step_nx = finish ? ST_IDLE : ST_WAIT;
      default: step_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else     step <= step_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      bank_q <= '0;
      main_q <= 1'b0;
    end else if (accept) begin
      page_q <= req_page;
      bank_q <= req_bank;
      main_q <= req_main;
    end
  end

  nprs_word_gen #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .ECC_OFS(ECC_OFS),
    .INT_BASE(INT_BASE), .INT_STRIDE(INT_STRIDE), .PAGE_COUNT(1)
  ) u_words (
    .step(step), .page(page_q), .bank(bank_q), .main_area(main_q),
    .wr(g_wr), .space(g_space), .addr(g_addr), .data(g_data),
    .rd(g_rd), .stat_addr(g_stat)
  );

  nprs_poll_timer #(
    .POLL_IVL(POLL_IVL), .MAX_POLLS(MAX_POLLS)
  ) u_timer (
    .clk(clk), .rst(rst), .start(accept), .arm(step == ST_WAIT),
    .miss(miss), .tick(tick), .last_poll(last_poll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en       <= 1'b0;
      wr_space    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      rd_en       <= 1'b0;
      rd_addr     <= '0;
      done        <= 1'b0;
      err_uncor   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      wr_en       <= g_wr;
      wr_space    <= g_space;
      wr_addr     <= g_addr;
      wr_data     <= g_data;
      rd_en       <= g_rd;
      rd_addr     <= g_stat;
      done        <= finish;
      err_uncor   <= in_chk && st_uncor;
      err_timeout <= miss && last_poll;
    end
  end

endmodule

// File: rtl/nprs_checker.sv
module nprs_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_en,
  input logic              wr_space,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic              done,
  input logic              err_uncor,
  input logic              err_timeout
);

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_flags_need_done: assert property (@(posedge clk) disable iff (rst)
    (err_uncor || err_timeout) |-> done);

  a_r6_uncor_excludes_timeout: assert property (@(posedge clk) disable iff (rst)
    !(err_uncor && err_timeout));

  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_no_bus_when_idle_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !req_ready);

  a_r5_read_write_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

  a_r4_window_offsets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_space) |-> (wr_addr == ADDR_W'(0) || wr_addr == ADDR_W'('h10)));

  a_r5_single_read_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

endmodule

bind nand_page_read_seq nprs_checker #(.ADDR_W(ADDR_W)) u_nprs_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .rd_en(rd_en),
  .done(done), .err_uncor(err_uncor), .err_timeout(err_timeout)
);

// File: tb/nand_page_read_seq_test.sv
module nand_page_read_seq_test;

  localparam int ADDR_W = 12;
  localparam int PAGE_W = 24;
  localparam int BANK_W = 2;
  localparam int ECC_OFS = 'h0E0;
  localparam int INT_BASE = 'h410;
  localparam int INT_STRIDE = 'h050;
  localparam int LOAD_BIT = 12;
  localparam int UNCOR_BIT = 0;
  localparam int POLL_IVL = 3;
  localparam int MAX_POLLS = 5;
  localparam int LOADW = 1 << LOAD_BIT;
  localparam int UNCW = 1 << UNCOR_BIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_main = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [PAGE_W-1:0] req_page = '0;
  logic [31:0] rd_data;
  logic req_ready, wr_en, wr_space, rd_en, done, err_uncor, err_timeout;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  nand_page_read_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .ECC_OFS(ECC_OFS),
    .INT_BASE(INT_BASE), .INT_STRIDE(INT_STRIDE), .LOAD_BIT(LOAD_BIT),
    .UNCOR_BIT(UNCOR_BIT), .POLL_IVL(POLL_IVL), .MAX_POLLS(MAX_POLLS)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_main(req_main), .req_bank(req_bank), .req_page(req_page),
    .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .err_uncor(err_uncor), .err_timeout(err_timeout)
  );

  typedef struct {
    bit wr; bit sp; int addr; int data;
    bit rd; int raddr;
    bit dn; bit eu; bit et; bit rdy;
    string tag;
  } rec_t;

  rec_t exp_q[$];
  int   status_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   run_mon = 1'b0;

  // Controller model: answers each status read with the next scripted word.
  always @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= (status_q.size() > 0) ? status_q.pop_front() : 0;
  end

  function automatic rec_t blank(bit rdy, string tag);
    rec_t r;
    r.wr = 0; r.sp = 0; r.addr = 0; r.data = 0; r.rd = 0; r.raddr = 0;
    r.dn = 0; r.eu = 0; r.et = 0; r.rdy = rdy; r.tag = tag;
    return r;
  endfunction

  function automatic void push_wr(bit sp, int addr, int data, string tag);
    rec_t r = blank(1'b0, tag);
    r.wr = 1; r.sp = sp; r.addr = addr; r.data = data;
    exp_q.push_back(r);
  endfunction

  // Cycle-by-cycle reference comparison.
  always @(negedge clk) begin
    if (run_mon) begin
      rec_t r;
      bit bad;
      r = (exp_q.size() > 0) ? exp_q.pop_front() : blank(1'b1, "R1");
      bad = (wr_en !== r.wr) || (rd_en !== r.rd) || (done !== r.dn) ||
            (err_uncor !== r.eu) || (err_timeout !== r.et) || (req_ready !== r.rdy);
      if (r.wr && ((wr_space !== r.sp) || (wr_addr !== ADDR_W'(r.addr)) ||
                   (wr_data !== 32'(r.data)))) bad = 1'b1;
      if (r.rd && (rd_addr !== ADDR_W'(r.raddr))) bad = 1'b1;
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s t=%0t: got wr=%0b sp=%0b a=%h d=%h rd=%0b ra=%h dn=%0b eu=%0b et=%0b rdy=%0b; expected wr=%0b sp=%0b a=%h d=%h rd=%0b ra=%h dn=%0b eu=%0b et=%0b rdy=%0b",
                 r.tag, $time, wr_en, wr_space, wr_addr, wr_data, rd_en, rd_addr,
                 done, err_uncor, err_timeout, req_ready,
                 r.wr, r.sp, r.addr[ADDR_W-1:0], r.data, r.rd, r.raddr[ADDR_W-1:0],
                 r.dn, r.eu, r.et, r.rdy);
      end
    end
  end

  task automatic run_req(bit main_a, int bank, int page, int script[$], bit poke);
    int tgt = (bank << 24) | page;
    int sta = INT_BASE + bank * INT_STRIDE;
    int outcome = 0;  // 1 ok, 2 uncorrectable, 3 timeout
    int npoll = 0;
    @(posedge clk); #1;
    for (int p = 0; p < MAX_POLLS && outcome == 0; p++) begin
      int w = (p < script.size()) ? script[p] : 0;
      npoll++;
      if (w & UNCW)              outcome = 2;
      else if (w & LOADW)        outcome = 1;
      else if (p == MAX_POLLS-1) outcome = 3;
    end
    foreach (script[i]) status_q.push_back(script[i]);
    exp_q.push_back(blank(1'b1, "R9"));
    exp_q.push_back(blank(1'b0, "R4"));
    push_wr(0, ECC_OFS, main_a ? 1 : 0, "R2");
    push_wr(0, sta, 'hFFFF, "R3");
    push_wr(1, 'h0, (2 << 26) | tgt, "R4");
    push_wr(1, 'h10, main_a ? 'h42 : 'h41, "R4");
    push_wr(1, 'h0, (2 << 26) | tgt, "R4");
    push_wr(1, 'h10, 'h2001, "R4");
    push_wr(1, 'h0, (1 << 26) | tgt, "R4");
    for (int p = 0; p < npoll; p++) begin
      rec_t r;
      for (int k = 0; k < POLL_IVL; k++) exp_q.push_back(blank(1'b0, "R5"));
      r = blank(1'b0, "R5"); r.rd = 1; r.raddr = sta; exp_q.push_back(r);
      exp_q.push_back(blank(1'b0, "R5"));
      if (p == npoll - 1) begin
        r = blank(1'b1, outcome == 2 ? "R6" : (outcome == 3 ? "R8" : "R7"));
        r.dn = 1; r.eu = (outcome == 2); r.et = (outcome == 3);
        exp_q.push_back(r);
      end else begin
        exp_q.push_back(blank(1'b0, "R8"));
      end
    end
    exp_q.push_back(blank(1'b1, "R10"));
    req_valid = 1'b1; req_main = main_a;
    req_bank = BANK_W'(bank); req_page = PAGE_W'(page);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      repeat (2) @(posedge clk);
      #1;
      req_valid = 1'b1; req_main = ~main_a;
      req_bank = ~BANK_W'(bank); req_page = ~PAGE_W'(page);
      repeat (4) @(posedge clk);
      #1;
      req_valid = 1'b0;
    end
    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (!(req_ready === 1'b1 && wr_en === 1'b0 && rd_en === 1'b0 && done === 1'b0 &&
          err_uncor === 1'b0 && err_timeout === 1'b0)) begin
      fails++;
      $display("FAIL R1 reset: got rdy=%0b wr=%0b rd=%0b dn=%0b eu=%0b et=%0b, expected 1 0 0 0 0 0",
               req_ready, wr_en, rd_en, done, err_uncor, err_timeout);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    run_mon = 1'b1;
    repeat (3) @(posedge clk);
    // R7: main read, completion on third poll
    run_req(1'b1, 1, 'h012345, '{0, 0, LOADW}, 1'b0);
    // R6: both bits in the first word, error has priority
    run_req(1'b0, 2, 'h0000A0, '{UNCW | LOADW}, 1'b0);
    // R6: unrelated bit first, then uncorrectable
    run_req(1'b0, 0, 'h000000, '{'h0002, UNCW}, 1'b0);
    // R8 timeout, R9 request while busy ignored
    run_req(1'b1, 3, 'hFFFFFF, '{}, 1'b1);
    // R8: completion on the last allowed poll, budget restarted
    run_req(1'b1, 0, 'h000007, '{0, 0, 0, 0, LOADW}, 1'b0);
    // R6: both bits on the last allowed poll
    run_req(1'b0, 1, 'h800001, '{0, 0, 0, 'h0004, LOADW | UNCW}, 1'b1);
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule